// File: doc/BRIEF.md
# Raw Symbol Transmit Serializer

This block is the raw transmit task of a four-level symbol modem. A host fills a six-byte data buffer, then issues a start command. The block copies the six bytes out of the buffer, one per clock, into an internal holding frame. It then shifts them out as 24 two-bit symbols, one symbol on each cycle in which the symbol-rate strobe is high. No check bits, error-correction bits, interleaving or inserted status symbols are added, so any pattern, including sync preambles and test sequences, reaches the symbol output unchanged.

The buffer is handed back to the host as soon as the copy is complete, not when the last symbol leaves. A buffer-free flag rises and an interrupt flag pulses at that moment, so the host can load and start the next task while the current one is still being sent. A task started in this way goes out directly after the last symbol of the running one, with no idle strobe between them. At most one task is sending and one is held in the frame at any time. A further start is accepted, but its copy waits until the held frame moves into the shifter.

Top module: `raw_sym_tx`

## Requirements
- R1: After reset, sym_valid is 0, sym_out is 2'b00, buf_free is 1 and irq is 0.
- R2: A write with buf_wr_en high while buf_free is 1 stores buf_wr_data at buffer address 0 to 5. Writes to addresses 6 and 7 change nothing.
- R3: A cycle with cmd_start high while buf_free is 1 starts a task, and buf_free is 0 in the next cycle. A cmd_start while buf_free is 0 is ignored and sends nothing extra.
- R4: Buffer writes made while buf_free is 0 are ignored and do not alter what is sent.
- R5: When the holding frame is empty, buf_free returns to 1 on the sixth clock edge after the accepting edge. irq is high for exactly that one cycle.
- R6: Buffer byte 0 is sent first and byte 5 last. Inside a byte, bits [7:6] are sent first, then [5:4], [3:2] and [1:0]. Every byte value passes through unchanged.
- R7: Each accepted task yields exactly 24 strobes with sym_valid high. While sym_valid is high, sym_out and sym_valid hold between strobes.
- R8: When no task is sending, sym_valid is 0 and sym_out is 2'b00.
- R9: If a further task is held when the last symbol of the running task is strobed, its first symbol is presented in the next cycle and sym_valid does not drop.
- R10: If a task is started while another task is already held, buf_free stays 0 until the held task moves into the shifter and the new copy completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_wr_en | input | 1 | Host write strobe for the data buffer |
| buf_wr_addr | input | 3 | Buffer byte address |
| buf_wr_data | input | 8 | Byte to store |
| cmd_start | input | 1 | Start a raw transmit task |
| sym_stb | input | 1 | Symbol-rate enable, one symbol per high cycle |
| sym_out | output | 2 | Current four-level symbol |
| sym_valid | output | 1 | High while a task's symbols are being presented |
| buf_free | output | 1 | Buffer may be loaded and a task started |
| irq | output | 1 | One-cycle pulse when a buffer copy completes |

## Verification
The bench first goes after the handover points. A design that released the buffer late would miss the sixth-edge timing. A design that shifted the wrong bit pair first, or walked the bytes in reverse, would scramble every directed and random pattern. Back-to-back tasks are sent with the strobe high every cycle, so a one-strobe gap between tasks would show as sym_valid dropping. Starts and writes are also issued while the buffer is locked, including a third start while a task is already held. A design that honoured them would emit extra or corrupted symbols, or raise buf_free too early.

// File: rtl/raw_tx_pkg.sv
package raw_tx_pkg;
   // Slot state of the fetch sequencer
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,   // no copy requested
      FS_WAIT = 2'd1,   // copy requested, holding frame still occupied
      FS_COPY = 2'd2    // copying bytes into the holding frame
   } fetch_state_e;
endpackage

// File: rtl/raw_tx_buf.sv
module raw_tx_buf #(
   parameter int BYTE_BITS = 8,
   parameter int NUM_BYTES = 6,
   parameter int ADDR_BITS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_BITS-1:0] wr_addr,
   input  logic [BYTE_BITS-1:0] wr_data,
   input  logic                 wr_allow,
   input  logic [ADDR_BITS-1:0] rd_idx,
   output logic [BYTE_BITS-1:0] rd_data
);
   localparam int FLAT_W = NUM_BYTES * BYTE_BITS;

   logic [BYTE_BITS-1:0] mem [NUM_BYTES];
   logic [FLAT_W-1:0]    mem_flat;

   generate
      for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
         logic [BYTE_BITS-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_allow && (wr_addr == ADDR_BITS'(i)))
               q <= wr_data;
         end
         assign mem[i] = q;
         assign mem_flat[i*BYTE_BITS +: BYTE_BITS] = q;
      end
   endgenerate

   assign rd_data = mem[rd_idx];

   // R4: a write while the buffer is locked leaves every byte untouched
   assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_allow) |=> $stable(mem_flat));

   // R2: addresses past the last byte change nothing
   assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) >= NUM_BYTES)) |=> $stable(mem_flat));
endmodule

// File: rtl/raw_tx_fetch.sv
module raw_tx_fetch
   import raw_tx_pkg::*;
#(
   parameter int BYTE_BITS = 8,
   parameter int NUM_BYTES = 6,
   parameter int ADDR_BITS = 3,
   localparam int FRAME_BITS = BYTE_BITS * NUM_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_start,
   input  logic                  pend_take,
   input  logic [BYTE_BITS-1:0]  rd_data,
   output logic [ADDR_BITS-1:0]  rd_idx,
   output logic                  buf_free,
   output logic                  irq,
   output logic                  pend_full,
   output logic [FRAME_BITS-1:0] pend_frame
);
   localparam logic [ADDR_BITS-1:0] LAST_IDX = ADDR_BITS'(NUM_BYTES - 1);

   fetch_state_e         state;
   logic [ADDR_BITS-1:0] idx;
   logic [BYTE_BITS-1:0] pend [NUM_BYTES];
   logic                 accept;
   logic                 copy;

   assign accept = cmd_start && buf_free;
   assign copy   = (state != FS_IDLE) && !pend_full;
   assign rd_idx = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FS_IDLE;
         idx       <= '0;
         buf_free  <= 1'b1;
         irq       <= 1'b0;
         pend_full <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (accept) begin
            buf_free <= 1'b0;
            idx      <= '0;
            state    <= pend_full ? FS_WAIT : FS_COPY;
         end else if (copy) begin
            state <= FS_COPY;
            if (idx == LAST_IDX) begin
               idx       <= '0;
               state     <= FS_IDLE;
               pend_full <= 1'b1;
               buf_free  <= 1'b1;
               irq       <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
         if (pend_take)
            pend_full <= 1'b0;
      end
   end

   generate
      for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend[k] <= '0;
            else if (copy && (idx == ADDR_BITS'(k)))
               pend[k] <= rd_data;
         end
         // byte 0 occupies the top of the frame so it leaves first
         assign pend_frame[FRAME_BITS-1-k*BYTE_BITS -: BYTE_BITS] = pend[k];
      end
   endgenerate

   // R3: an accepted start locks the buffer on the next cycle
   assert_accept_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !buf_free);

   // R5: the interrupt pulse marks a completed copy into the holding frame
   assert_irq_with_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (buf_free && pend_full));

   // R5: the interrupt lasts a single cycle
   assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10: a copy waiting on an occupied frame keeps the buffer locked
   assert_wait_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == FS_WAIT) && pend_full && !pend_take) |=> !buf_free);
endmodule

// File: rtl/raw_tx_shift.sv
module raw_tx_shift #(
   parameter int           SYM_BITS  = 2,
   parameter int           BYTE_BITS = 8,
   parameter int           NUM_BYTES = 6,
   parameter bit           MSB_FIRST = 1'b1,
   parameter logic [SYM_BITS-1:0] IDLE_SYM = '0,
   localparam int FRAME_BITS = BYTE_BITS * NUM_BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sym_stb,
   input  logic                  pend_full,
   input  logic [FRAME_BITS-1:0] pend_frame,
   output logic                  pend_take,
   output logic [SYM_BITS-1:0]   sym_out,
   output logic                  sym_valid
);
   localparam int SYMS_PER_BYTE = BYTE_BITS / SYM_BITS;
   localparam int NUM_SYMS      = SYMS_PER_BYTE * NUM_BYTES;
   localparam int CNT_W         = $clog2(NUM_SYMS + 1);

   logic [FRAME_BITS-1:0] ordered;
   logic [FRAME_BITS-1:0] sh;
   logic [CNT_W-1:0]      cnt;
   logic                  active;
   logic                  last;

   // Pick the symbol order inside each byte
   generate
      if (MSB_FIRST) begin : g_msb
         assign ordered = pend_frame;
      end else begin : g_lsb
         for (genvar b = 0; b < NUM_BYTES; b++) begin : g_b
            for (genvar j = 0; j < SYMS_PER_BYTE; j++) begin : g_s
               assign ordered[b*BYTE_BITS + (SYMS_PER_BYTE-1-j)*SYM_BITS +: SYM_BITS] =
                  pend_frame[b*BYTE_BITS + j*SYM_BITS +: SYM_BITS];
            end
         end
      end
   endgenerate

   assign active    = (cnt != '0);
   assign last      = active && sym_stb && (cnt == CNT_W'(1));
   assign pend_take = pend_full && (!active || last);
   assign sym_valid = active;
   assign sym_out   = active ? sh[FRAME_BITS-1 -: SYM_BITS] : IDLE_SYM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (pend_take) begin
         sh  <= ordered;
         cnt <= CNT_W'(NUM_SYMS);
      end else if (active && sym_stb) begin
         sh  <= sh << SYM_BITS;
         cnt <= cnt - 1'b1;
      end
   end

   // R7: between strobes the presented symbol holds
   assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !sym_stb) |=> (sym_valid && $stable(sym_out)));

   // R7: a task only ends on a strobe
   assert_end_on_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sym_valid) |-> $past(sym_stb));

   // R9: a held task follows the running one without a gap
   assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_stb && pend_full) |=> sym_valid);
endmodule

// File: rtl/raw_sym_tx.sv
module raw_sym_tx #(
   parameter int SYM_BITS  = 2,
   parameter int BYTE_BITS = 8,
   parameter int NUM_BYTES = 6,
   parameter bit MSB_FIRST = 1'b1,
   parameter logic [SYM_BITS-1:0] IDLE_SYM = '0,
   localparam int ADDR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) + ((NUM_BYTES & (NUM_BYTES - 1)) == 0 ? 0 : 0) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 buf_wr_en,
   input  logic [ADDR_W-1:0]    buf_wr_addr,
   input  logic [BYTE_BITS-1:0] buf_wr_data,
   input  logic                 cmd_start,
   input  logic                 sym_stb,
   output logic [SYM_BITS-1:0]  sym_out,
   output logic                 sym_valid,
   output logic                 buf_free,
   output logic                 irq
);
   localparam int FRAME_BITS = BYTE_BITS * NUM_BYTES;

   generate
      if ((BYTE_BITS % SYM_BITS) != 0) begin : g_bad_sym
         $error("BYTE_BITS must be a multiple of SYM_BITS");
      end
      if (NUM_BYTES < 1) begin : g_bad_bytes
         $error("NUM_BYTES must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0]     rd_idx;
   logic [BYTE_BITS-1:0]  rd_data;
   logic                  pend_full;
   logic                  pend_take;
   logic [FRAME_BITS-1:0] pend_frame;

   raw_tx_buf #(
      .BYTE_BITS (BYTE_BITS),
      .NUM_BYTES (NUM_BYTES),
      .ADDR_BITS (ADDR_W)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (buf_wr_en),
      .wr_addr  (buf_wr_addr),
      .wr_data  (buf_wr_data),
      .wr_allow (buf_free),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data)
   );

   raw_tx_fetch #(
      .BYTE_BITS (BYTE_BITS),
      .NUM_BYTES (NUM_BYTES),
      .ADDR_BITS (ADDR_W)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start),
      .pend_take  (pend_take),
      .rd_data    (rd_data),
      .rd_idx     (rd_idx),
      .buf_free   (buf_free),
      .irq        (irq),
      .pend_full  (pend_full),
      .pend_frame (pend_frame)
   );

   raw_tx_shift #(
      .SYM_BITS  (SYM_BITS),
      .BYTE_BITS (BYTE_BITS),
      .NUM_BYTES (NUM_BYTES),
      .MSB_FIRST (MSB_FIRST),
      .IDLE_SYM  (IDLE_SYM)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sym_stb    (sym_stb),
      .pend_full  (pend_full),
      .pend_frame (pend_frame),
      .pend_take  (pend_take),
      .sym_out    (sym_out),
      .sym_valid  (sym_valid)
   );

   // R1: the buffer is free on the first cycle out of reset
   assert_reset_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> buf_free);
endmodule

// File: tb/sim_raw_sym_tx.sv
module sim_raw_sym_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       buf_wr_en = 1'b0;
   logic [2:0] buf_wr_addr = '0;
   logic [7:0] buf_wr_data = '0;
   logic       cmd_start = 1'b0;
   logic       sym_stb = 1'b0;
   logic [1:0] sym_out;
   logic       sym_valid;
   logic       buf_free;
   logic       irq;

   int         n_cmp = 0;
   int         n_bad = 0;
   int         stb_mode = 0;       // 0 frozen, 1 every cycle, 2 random
   string      cur_req = "R6";
   logic [7:0] shadow [6];
   logic [1:0] expq [$];
   bit         done = 1'b0;

   always #10 clk = ~clk;           // 50 MHz

   raw_sym_tx u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .buf_wr_en   (buf_wr_en),
      .buf_wr_addr (buf_wr_addr),
      .buf_wr_data (buf_wr_data),
      .cmd_start   (cmd_start),
      .sym_stb     (sym_stb),
      .sym_out     (sym_out),
      .sym_valid   (sym_valid),
      .buf_free    (buf_free),
      .irq         (irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Expected symbols of one task: byte 0 first, top bit pair first
   function automatic void push_task();
      for (int b = 0; b < 6; b++)
         for (int s = 0; s < 4; s++)
            expq.push_back(shadow[b][7-2*s -: 2]);
   endfunction

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      buf_wr_en = 1'b1; buf_wr_addr = a; buf_wr_data = d;
      if (buf_free && a < 3'd6) shadow[a] = d;
      @(negedge clk);
      buf_wr_en = 1'b0;
   endtask

   task automatic start();
      cmd_start = 1'b1;
      if (buf_free) push_task();
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_free();
      for (int i = 0; i < 400 && !buf_free; i++) @(negedge clk);
   endtask

   // Strobe driver and symbol scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (stb_mode == 0)      sym_stb = 1'b0;
         else if (stb_mode == 1) sym_stb = 1'b1;
         else                    sym_stb = ($urandom_range(0, 99) < 55);
         if (rst_n) begin
            if (!sym_valid) begin
               check(sym_out == 2'b00, "R8", sym_out, 0);
            end else if (sym_stb) begin
               if (expq.size() == 0) begin
                  check(1'b0, "R7", 1, 0);
               end else begin
                  logic [1:0] e;
                  e = expq.pop_front();
                  check(sym_out == e, cur_req, sym_out, e);
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         summary();
      end
   end

   initial begin
      void'($urandom(32'd929));
      for (int i = 0; i < 6; i++) shadow[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(sym_valid == 1'b0, "R1", sym_valid, 0);
      check(sym_out == 2'b00, "R1", sym_out, 0);
      check(buf_free == 1'b1, "R1", buf_free, 1);
      check(irq == 1'b0, "R1", irq, 0);

      // Directed task A with out-of-range writes (R2) and timing (R5)
      cur_req = "R2";
      wr(3'd0, 8'h1B); wr(3'd1, 8'hE4); wr(3'd2, 8'hC3);
      wr(3'd3, 8'h5A); wr(3'd4, 8'h96); wr(3'd5, 8'h0F);
      wr(3'd6, 8'hFF); wr(3'd7, 8'hAA);
      start();                                  // now at N0
      check(buf_free == 1'b0, "R3", buf_free, 0);
      cmd_start = 1'b1;                          // ignored start, R3
      @(negedge clk);                            // N1
      cmd_start = 1'b0;
      check(buf_free == 1'b0, "R5", buf_free, 0);
      wr(3'd5, 8'h77);                           // locked write, R4 -> N2
      for (int n = 2; n < 6; n++) begin
         check(buf_free == 1'b0 && irq == 1'b0, "R5", buf_free, 0);
         @(negedge clk);
      end
      check(buf_free == 1'b1, "R5", buf_free, 1);   // N6
      check(irq == 1'b1, "R5", irq, 1);
      @(negedge clk);
      check(irq == 1'b0, "R5", irq, 0);
      check(sym_valid == 1'b1, "R6", sym_valid, 1);
      check(sym_out == 2'b00, "R6", sym_out, 0);    // top pair of 8'h1B

      // Task B held, task C waits (R10)
      cur_req = "R6";
      wr(3'd0, 8'hFF); wr(3'd1, 8'h00); wr(3'd2, 8'h55);
      wr(3'd3, 8'hAA); wr(3'd4, 8'h33); wr(3'd5, 8'hCC);
      start();
      wait_free();
      check(buf_free == 1'b1, "R10", buf_free, 1);
      wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56);
      wr(3'd3, 8'h78); wr(3'd4, 8'h9A); wr(3'd5, 8'hBC);
      start();
      for (int n = 0; n < 20; n++) begin
         check(buf_free == 1'b0, "R10", buf_free, 0);
         @(negedge clk);
      end

      // Gap-free handover across A, B, C (R9)
      cur_req = "R9";
      stb_mode = 1;
      @(negedge clk);
      for (int n = 0; n < 70; n++) begin
         check(sym_valid == 1'b1, "R9", sym_valid, 1);
         @(negedge clk);
      end
      wait_free();
      for (int n = 0; n < 10; n++) @(negedge clk);

      // Random tasks mixed with locked writes and starts
      cur_req = "R6";
      stb_mode = 2;
      for (int t = 0; t < 25; t++) begin
         int gap;
         gap = $urandom_range(0, 30);
         for (int g = 0; g < gap; g++) @(negedge clk);
         for (int w = 0; w < 9; w++)
            wr(3'($urandom_range(0, 7)), 8'($urandom));
         start();
      end

      // Drain and idle (R7, R8)
      stb_mode = 1;
      for (int i = 0; i < 400 && (expq.size() != 0 || sym_valid); i++) @(negedge clk);
      check(expq.size() == 0, "R7", expq.size(), 0);
      for (int n = 0; n < 5; n++) begin
         check(sym_valid == 1'b0 && sym_out == 2'b00, "R8", sym_valid, 0);
         @(negedge clk);
      end
      check(buf_free == 1'b1, "R3", buf_free, 1);
      done = 1'b1;
      summary();
   end
endmodule